// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block is a slave serial port that holds a small bank of 10-bit configuration registers for a sensor front end. A host drives three lines: a serial clock, a serial data input and an active-low load line that frames a transfer. The port has one readback output. A polarity pin picks the serial clock edge on which input bits are taken. The readback output always moves on the other edge.

Every 16-bit frame is either a register write or a read request. Bit 15 is the direction (0 write, 1 read), bits 14..10 are the address and bits 9..0 are the data. A read request captures the addressed register. That word is then shifted out during the frame that follows, starting at a fixed clock count. If the host has released the load line before that point, the word starts when the load line next goes low.

The bank applies reset defaults. It has a self-clearing soft reset bit and presents a clamped gain code to the downstream logic. The serial lines are resynchronised into the system clock domain, so the serial clock must be several times slower than the system clock.

Top module: `tws_serial_regs`

## Requirements
- R1: A write frame (bit 15 = 0, address in bits 14..10, data in bits 9..0, MSB sent first) stores the data in the addressed register. A later read of that address returns the stored value. Registers change only when a frame completes.
- R2: With `ser_edge_sel` high, input bits are taken on rising serial clock edges. With it low, they are taken on falling edges. `ser_dout` only changes on the opposite edge.
- R3: Any number of 16-bit frames may be sent while `ser_load_n` stays low, and each one is decoded on its own.
- R4: For a read request (bit 15 = 1), the data field is ignored and no register changes. If load stays low, the MSB of the 16-bit readback word is valid for the 18th input edge counted from the start of the request, and the LSB for the 33rd. Word bits 15..10 are 0 and bits 9..0 carry the register.
- R5: If load is high when the readback would start, the word's MSB is driven once load next falls. The following 15 output edges give the remaining bits, so the host takes the word on the 16 input edges of that window.
- R6: After `rst_n` is held low, the registers read: address 0 = 0x380 (bits 9, 8 and 7 set), address 6 = 64, address 9 = 0x010 (bit 4 set), and every other mapped register = 0.
- R7: Writing address 0 with data bit 0 set returns every register to its R6 default, including address 0. Bit 0 of address 0 always reads 0.
- R8: `gain_code` equals the value of address 1 when that value is at most 720, and 720 otherwise. Reading address 1 back returns the stored, unclamped code.
- R9: The mapped addresses are 0, 1, 2, 3, 6, 7, 8, 9 and 10. Reads of any other address return 0, and writes to them change no register.
- R10: When `ser_load_n` rises, the bit count clears, so a partial frame has no effect and the next frame aligns from its first bit.
- R11: Registers stay writable after address 0 bit 9 (standby-not) has been written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_load_n | input | 1 | Active-low transfer frame |
| ser_edge_sel | input | 1 | 1: input taken on rising serial edge, 0: on falling |
| ser_dout | output | 1 | Readback data |
| ctrl_bits | output | 10 | Register 0 (mode control) |
| gain_code | output | 10 | Register 1, clamped to 720 |
| dac_a_code | output | 10 | Register 2 |
| dac_b_code | output | 10 | Register 3 |
| black_ref | output | 10 | Register 6 (black reference level) |
| blank_val | output | 10 | Register 7 (blanking output value) |
| polarity_bits | output | 10 | Register 8 (strobe polarities) |
| timing_a | output | 10 | Register 9 |
| timing_b | output | 10 | Register 10 |

## Verification
The bench drives every address in both edge polarities, packing writes back to back, and moves the data line halfway between the input edge and the output edge. A port that samples on the wrong edge therefore reads the next bit and corrupts every stored word. Readbacks are taken both with load held low, which catches a word that starts one edge early or late, and with load released between request and data, which exposes a port that drops deferred words. The gain is swept across the 720 limit so that an off-by-one clamp or a clamp applied to the stored copy shows up. Partial frames, soft reset, hardware reset and writes in standby are each followed by reads that would show stale, shifted or lost state.

// File: rtl/tws_pkg.sv
// Package: shared sizes, address map and reset defaults of the
// three-wire register port. Assumes a 1+5+10 bit frame layout.
package tws_pkg;
    localparam int AW        = 5;
    localparam int DW        = 10;
    localparam int FW        = 1 + AW + DW;
    localparam int NREG      = 11;
    localparam int GAIN_MAX  = 720;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_GAIN  = 1;
    localparam int ADDR_DACA  = 2;
    localparam int ADDR_DACB  = 3;
    localparam int ADDR_BLACK = 6;
    localparam int ADDR_BLANK = 7;
    localparam int ADDR_POL   = 8;
    localparam int ADDR_TIMA  = 9;
    localparam int ADDR_TIMB  = 10;

    // Reset value of register idx
    function automatic logic [DW-1:0] reg_default(input int idx);
        logic [DW-1:0] v;
        v = '0;
        if (idx == ADDR_CTRL)  v = DW'(10'h380);
        if (idx == ADDR_BLACK) v = DW'(64);
        if (idx == ADDR_TIMA)  v = DW'(10'h010);
        return v;
    endfunction

    // True when idx names a mapped register
    function automatic logic reg_present(input int idx);
        return (idx >= 0) && (idx < NREG) && (idx != 4) && (idx != 5);
    endfunction
endpackage

// File: rtl/tws_sync.sv
// Module: resynchronises the serial lines into clk and turns serial
// clock transitions into one-cycle input and output edge strobes.
// Assumes the serial clock half period spans at least four clk cycles.
module tws_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_din,
    input  logic ser_load_n,
    input  logic ser_edge_sel,
    output logic samp_ev,
    output logic launch_ev,
    output logic load_act,
    output logic load_fall,
    output logic din_s
);
    logic sclk_m, sclk_s, sclk_d;
    logic din_m;
    logic ld_m, ld_s, ld_d;
    logic sel_m, sel_s;
    logic rise, fall;

    // two-flop synchronisers plus one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_m <= 1'b0; sclk_s <= 1'b0; sclk_d <= 1'b0;
            din_m  <= 1'b0; din_s  <= 1'b0;
            ld_m   <= 1'b1; ld_s   <= 1'b1; ld_d   <= 1'b1;
            sel_m  <= 1'b1; sel_s  <= 1'b1;
        end else begin
            sclk_m <= ser_clk;    sclk_s <= sclk_m; sclk_d <= sclk_s;
            din_m  <= ser_din;    din_s  <= din_m;
            ld_m   <= ser_load_n; ld_s   <= ld_m;   ld_d   <= ld_s;
            sel_m  <= ser_edge_sel; sel_s <= sel_m;
        end
    end

    // edge strobes, gated by an active transfer window
    always_comb begin
        rise      = sclk_s & ~sclk_d;
        fall      = ~sclk_s & sclk_d;
        load_act  = ~ld_s;
        load_fall = ~ld_s & ld_d;
        samp_ev   = load_act & (sel_s ? rise : fall);
        launch_ev = load_act & (sel_s ? fall : rise);
    end
endmodule

// File: rtl/tws_frame.sv
// Module: shifts input bits MSB first and emits each full frame as a
// one-cycle strobe. Assumes strobes from tws_sync; load release clears.
module tws_frame #(
    parameter int FW = tws_pkg::FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_ev,
    input  logic          load_act,
    input  logic          din_s,
    output logic          frm_valid,
    output logic [FW-1:0] frm_word
);
    localparam int CW = $clog2(FW);
    logic [CW-1:0] cnt;
    logic [FW-1:0] sr;

    // bit counter and shift register; partial frames drop on load release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            sr        <= '0;
            frm_valid <= 1'b0;
            frm_word  <= '0;
        end else begin
            frm_valid <= 1'b0;
            if (!load_act) begin
                cnt <= '0;
            end else if (samp_ev) begin
                sr <= {sr[FW-2:0], din_s};
                if (cnt == CW'(FW-1)) begin
                    cnt       <= '0;
                    frm_valid <= 1'b1;
                    frm_word  <= {sr[FW-2:0], din_s};
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tws_regs.sv
// Module: register bank with per-address reset defaults, soft reset
// through control bit 0, and a combinational read mux. Unmapped
// addresses hold no storage and read zero.
module tws_regs #(
    parameter int AW   = tws_pkg::AW,
    parameter int DW   = tws_pkg::DW,
    parameter int NREG = tws_pkg::NREG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [NREG*DW-1:0] reg_flat
);
    logic soft_rst;

    // soft reset: a write to the control address with bit 0 set
    always_comb soft_rst = wr_en && (wr_addr == AW'(tws_pkg::ADDR_CTRL)) && wr_data[0];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (tws_pkg::reg_present(i)) begin : g_store
            localparam logic [DW-1:0] DEF = tws_pkg::reg_default(i);
            localparam bit IS_CTRL = (i == tws_pkg::ADDR_CTRL);
            logic [DW-1:0] q;
            // one register: default on either reset, else take writes
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) begin
                    q <= DEF;
                end else if (wr_en && wr_addr == AW'(i)) begin
                    if (IS_CTRL) q <= {wr_data[DW-1:1], 1'b0};
                    else         q <= wr_data;
                end
            end
            assign reg_flat[i*DW +: DW] = q;
        end else begin : g_hole
            assign reg_flat[i*DW +: DW] = '0;
        end
    end

    // read mux; addresses beyond the bank give zero
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREG; k++) begin
            if (rd_addr == AW'(k)) rd_data = reg_flat[k*DW +: DW];
        end
    end
endmodule

// File: rtl/tws_readout.sv
// Module: holds a captured read word and shifts it out MSB first on
// output edges. The word starts at the output edge that follows the
// first input edge after the request, or at the next load fall if
// load was released first.
module tws_readout #(
    parameter int FW = tws_pkg::FW,
    parameter int DW = tws_pkg::DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [DW-1:0] rd_data,
    input  logic          samp_ev,
    input  logic          launch_ev,
    input  logic          load_act,
    input  logic          load_fall,
    output logic          ser_dout
);
    localparam int CW = $clog2(FW);
    typedef enum logic [2:0] {S_IDLE, S_ARM, S_LAUNCH, S_DEFER, S_SHIFT} st_t;
    st_t           st;
    logic [FW-1:0] word;
    logic [CW-1:0] cnt;

    // readout sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            word     <= '0;
            cnt      <= '0;
            ser_dout <= 1'b0;
        end else if (rd_req) begin
            word     <= {{(FW-DW){1'b0}}, rd_data};
            st       <= S_ARM;
            ser_dout <= 1'b0;
        end else begin
            case (st)
                S_ARM: begin
                    if (!load_act)    st <= S_DEFER;
                    else if (samp_ev) st <= S_LAUNCH;
                end
                S_LAUNCH: begin
                    if (!load_act) begin
                        st <= S_DEFER;
                    end else if (launch_ev) begin
                        ser_dout <= word[FW-1];
                        word     <= word << 1;
                        cnt      <= '0;
                        st       <= S_SHIFT;
                    end
                end
                S_DEFER: begin
                    if (load_fall) begin
                        ser_dout <= word[FW-1];
                        word     <= word << 1;
                        cnt      <= '0;
                        st       <= S_SHIFT;
                    end
                end
                S_SHIFT: begin
                    if (!load_act) begin
                        st       <= S_IDLE;
                        ser_dout <= 1'b0;
                    end else if (launch_ev) begin
                        if (cnt == CW'(FW-1)) begin
                            st       <= S_IDLE;
                            ser_dout <= 1'b0;
                        end else begin
                            ser_dout <= word[FW-1];
                            word     <= word << 1;
                            cnt      <= cnt + 1'b1;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tws_serial_regs.sv
// Module: top of the three-wire register port. It joins the
// synchroniser, frame decoder, register bank and readout shifter, and
// presents each register with the gain code clamped to its limit.
module tws_serial_regs #(
    parameter int AW       = tws_pkg::AW,
    parameter int DW       = tws_pkg::DW,
    parameter int NREG     = tws_pkg::NREG,
    parameter int GAIN_MAX = tws_pkg::GAIN_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk,
    input  logic          ser_din,
    input  logic          ser_load_n,
    input  logic          ser_edge_sel,
    output logic          ser_dout,
    output logic [DW-1:0] ctrl_bits,
    output logic [DW-1:0] gain_code,
    output logic [DW-1:0] dac_a_code,
    output logic [DW-1:0] dac_b_code,
    output logic [DW-1:0] black_ref,
    output logic [DW-1:0] blank_val,
    output logic [DW-1:0] polarity_bits,
    output logic [DW-1:0] timing_a,
    output logic [DW-1:0] timing_b
);
    localparam int FW = 1 + AW + DW;
    localparam logic [DW-1:0] GMAX = DW'(GAIN_MAX);

    logic samp_ev, launch_ev, load_act, load_fall, din_s;
    logic frm_valid;
    logic [FW-1:0] frm_word;
    logic frm_read;
    logic [AW-1:0] frm_addr;
    logic [DW-1:0] frm_data;
    logic [DW-1:0] rd_data;
    logic [NREG*DW-1:0] reg_flat;
    logic [DW-1:0] gain_raw;

    tws_sync u_sync (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_load_n(ser_load_n), .ser_edge_sel(ser_edge_sel),
        .samp_ev(samp_ev), .launch_ev(launch_ev), .load_act(load_act),
        .load_fall(load_fall), .din_s(din_s)
    );

    tws_frame #(.FW(FW)) u_frame (
        .clk(clk), .rst_n(rst_n), .samp_ev(samp_ev), .load_act(load_act),
        .din_s(din_s), .frm_valid(frm_valid), .frm_word(frm_word)
    );

    // split the frame into direction, address and data fields
    always_comb begin
        frm_read = frm_word[FW-1];
        frm_addr = frm_word[FW-2 -: AW];
        frm_data = frm_word[DW-1:0];
    end

    tws_regs #(.AW(AW), .DW(DW), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(frm_valid && !frm_read),
        .wr_addr(frm_addr), .wr_data(frm_data), .rd_addr(frm_addr),
        .rd_data(rd_data), .reg_flat(reg_flat)
    );

    tws_readout #(.FW(FW), .DW(DW)) u_readout (
        .clk(clk), .rst_n(rst_n), .rd_req(frm_valid && frm_read),
        .rd_data(rd_data), .samp_ev(samp_ev), .launch_ev(launch_ev),
        .load_act(load_act), .load_fall(load_fall), .ser_dout(ser_dout)
    );

    // fan the bank out to named outputs; gain is limited here only
    always_comb begin
        ctrl_bits     = reg_flat[tws_pkg::ADDR_CTRL*DW  +: DW];
        gain_raw      = reg_flat[tws_pkg::ADDR_GAIN*DW  +: DW];
        dac_a_code    = reg_flat[tws_pkg::ADDR_DACA*DW  +: DW];
        dac_b_code    = reg_flat[tws_pkg::ADDR_DACB*DW  +: DW];
        black_ref     = reg_flat[tws_pkg::ADDR_BLACK*DW +: DW];
        blank_val     = reg_flat[tws_pkg::ADDR_BLANK*DW +: DW];
        polarity_bits = reg_flat[tws_pkg::ADDR_POL*DW   +: DW];
        timing_a      = reg_flat[tws_pkg::ADDR_TIMA*DW  +: DW];
        timing_b      = reg_flat[tws_pkg::ADDR_TIMB*DW  +: DW];
        gain_code     = (gain_raw > GMAX) ? GMAX : gain_raw;
    end
endmodule

// File: rtl/tws_checker.sv
// Module: property checker for tws_serial_regs, attached by bind.
// Assumes synchronous active-low reset.
module tws_checker #(
    parameter int AW   = tws_pkg::AW,
    parameter int DW   = tws_pkg::DW,
    parameter int NREG = tws_pkg::NREG,
    parameter int FW   = 1 + AW + DW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_valid,
    input logic [FW-1:0]    frm_word,
    input logic [NREG*DW-1:0] reg_flat,
    input logic             samp_ev,
    input logic             load_fall,
    input logic             ser_dout,
    input logic [DW-1:0]    gain_code,
    input logic [DW-1:0]    black_ref,
    input logic [DW-1:0]    ctrl_bits
);
    logic wr_frame, hole_addr, soft_hit;

    // decode helpers for the properties below
    always_comb begin
        wr_frame  = frm_valid && !frm_word[FW-1];
        hole_addr = !tws_pkg::reg_present(int'(frm_word[FW-2 -: AW]));
        soft_hit  = wr_frame && (frm_word[FW-2 -: AW] == '0) && frm_word[0];
    end

    assert_gain_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gain_code <= DW'(tws_pkg::GAIN_MAX));

    assert_hold_between_frames_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> $stable(reg_flat));

    assert_hole_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame && hole_addr) |=> $stable(reg_flat));

    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_hit |=> (black_ref == DW'(64) && ctrl_bits == DW'(10'h380)));

    assert_dout_still_on_input_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_ev && !load_fall) |=> $stable(ser_dout));
endmodule

bind tws_serial_regs tws_checker #(.AW(AW), .DW(DW), .NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_word(frm_word),
    .reg_flat(reg_flat), .samp_ev(samp_ev), .load_fall(load_fall),
    .ser_dout(ser_dout), .gain_code(gain_code), .black_ref(black_ref),
    .ctrl_bits(ctrl_bits)
);

// File: tb/tws_serial_regs_tb.sv
// Bench: sweeps every address in both edge polarities against an
// arithmetic model of the bank, plus targeted corner cases.
module tws_serial_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_din = 1'b0, ser_load_n = 1'b1, ser_edge_sel = 1'b1;
    logic ser_dout;
    logic [9:0] ctrl_bits, gain_code, dac_a_code, dac_b_code, black_ref;
    logic [9:0] blank_val, polarity_bits, timing_a, timing_b;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [9:0] model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    tws_serial_regs u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_load_n(ser_load_n), .ser_edge_sel(ser_edge_sel), .ser_dout(ser_dout),
        .ctrl_bits(ctrl_bits), .gain_code(gain_code), .dac_a_code(dac_a_code),
        .dac_b_code(dac_b_code), .black_ref(black_ref), .blank_val(blank_val),
        .polarity_bits(polarity_bits), .timing_a(timing_a), .timing_b(timing_b)
    );

    function automatic bit mapped(input int a);
        return (a <= 10) && (a != 4) && (a != 5);
    endfunction

    function automatic logic [9:0] dflt(input int a);
        if (a == 0) return 10'h380;
        if (a == 6) return 10'd64;
        if (a == 9) return 10'h010;
        return 10'h000;
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 32; a++) model[a] = mapped(a) ? dflt(a) : 10'h000;
    endtask

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial bit; the data line changes midway between the two edges
    task automatic ser_bit(input logic b, output logic seen);
        ser_din = b;
        wait_clk(H);
        seen = ser_dout;
        ser_clk = ser_edge_sel;
        wait_clk(H/2);
        ser_din = ~b;
        wait_clk(H/2);
        ser_clk = ~ser_edge_sel;
    endtask

    task automatic send_frame(input logic [15:0] w, output logic [15:0] cap);
        logic s;
        for (int i = 15; i >= 0; i--) begin
            ser_bit(w[i], s);
            cap[i] = s;
        end
    endtask

    task automatic begin_tx();
        ser_load_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic end_tx();
        wait_clk(H);
        ser_load_n = 1'b1;
        wait_clk(4*H);
    endtask

    task automatic do_write(input int a, input logic [9:0] d);
        logic [15:0] cap;
        begin_tx();
        send_frame({1'b0, 5'(a), d}, cap);
        end_tx();
        if (mapped(a)) model[a] = (a == 0) ? {d[9:1], 1'b0} : d;
        if (a == 0 && d[0]) model_reset();
    endtask

    // request plus data frame with load held low, one extra edge for the LSB
    task automatic do_read(input int a, output logic [15:0] got);
        logic [15:0] cap, cap2;
        logic last;
        begin_tx();
        send_frame({1'b1, 5'(a), 10'h2AB}, cap);
        send_frame({1'b0, 5'd31, 10'h000}, cap2);
        ser_bit(1'b0, last);
        end_tx();
        got = {cap2[14:0], last};
    endtask

    task automatic set_pol(input logic p);
        ser_edge_sel = p;
        ser_clk = ~p;
        wait_clk(4*H);
    endtask

    task automatic check_outputs(input string rq);
        chk({rq, " ctrl"},  {6'd0, ctrl_bits},  {6'd0, model[0]});
        chk({rq, " gain"},  {6'd0, gain_code},  {6'd0, (model[1] > 10'd720) ? 10'd720 : model[1]});
        chk({rq, " daca"},  {6'd0, dac_a_code}, {6'd0, model[2]});
        chk({rq, " dacb"},  {6'd0, dac_b_code}, {6'd0, model[3]});
        chk({rq, " black"}, {6'd0, black_ref},  {6'd0, model[6]});
        chk({rq, " blank"}, {6'd0, blank_val},  {6'd0, model[7]});
        chk({rq, " pol"},   {6'd0, polarity_bits}, {6'd0, model[8]});
        chk({rq, " tima"},  {6'd0, timing_a},   {6'd0, model[9]});
        chk({rq, " timb"},  {6'd0, timing_b},   {6'd0, model[10]});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] got, cap;
        model_reset();
        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(4);

        // R6: reset defaults at ports and through readback
        check_outputs("R6 reset");
        do_read(0, got); chk("R6 read ctrl", got, 16'h0380);
        do_read(6, got); chk("R6 read black", got, 16'h0040);
        do_read(9, got); chk("R6 read tima", got, 16'h0010);

        // R1 R2 R3 R9: back-to-back sweep of all addresses in both polarities
        for (int p = 1; p >= 0; p--) begin
            set_pol(p[0]);
            begin_tx();
            for (int a = 0; a < 32; a++) begin
                logic [9:0] d;
                d = 10'((a * 37 + 5 + p * 211) & 10'h3FF);
                if (a == 0) d = d & 10'h3FE;
                send_frame({1'b0, 5'(a), d}, cap);
                if (mapped(a)) model[a] = d;
            end
            end_tx();
            check_outputs(p ? "R2 R3 rising" : "R2 R3 falling");
            for (int a = 0; a < 32; a++) begin
                do_read(a, got);
                chk(mapped(a) ? "R1 R4 readback" : "R9 hole reads zero", got, {6'd0, model[a]});
            end
        end

        // R4: data field of a read request is ignored
        set_pol(1'b1);
        do_read(2, got);
        chk("R4 req data ignored", {6'd0, dac_a_code}, {6'd0, model[2]});
        chk("R4 readback upper zero", got, {6'd0, model[2]});

        // R5: deferred readback after load released
        begin_tx();
        send_frame({1'b1, 5'd7, 10'h3FF}, cap);
        end_tx();
        begin_tx();
        send_frame({1'b0, 5'd4, 10'h155}, cap);
        end_tx();
        chk("R5 deferred word", cap, {6'd0, model[7]});
        check_outputs("R5 R9 hole write");

        // R10: partial frame discarded, next frame aligns
        begin_tx();
        for (int i = 15; i >= 6; i--) begin
            logic s;
            ser_bit(i[0], s);
        end
        end_tx();
        check_outputs("R10 partial");
        do_write(3, 10'h2C3);
        chk("R10 aligned", {6'd0, dac_b_code}, 16'h02C3);

        // R8: gain sweep across the clamp
        for (int c = 700; c <= 740; c++) begin
            do_write(1, 10'(c));
            chk("R8 clamp", {6'd0, gain_code}, (c > 720) ? 16'd720 : 16'(c));
        end
        do_write(1, 10'h3FF);
        chk("R8 clamp top", {6'd0, gain_code}, 16'd720);
        do_read(1, got);
        chk("R8 raw readback", got, 16'h03FF);

        // R11: writes accepted in standby
        set_pol(1'b0);
        do_write(0, 10'h180);
        chk("R11 standby", {6'd0, ctrl_bits}, 16'h0180);
        do_write(2, 10'h055);
        chk("R11 write in standby", {6'd0, dac_a_code}, 16'h0055);
        do_read(2, got);
        chk("R11 readback", got, 16'h0055);

        // R7: soft reset restores defaults and reads bit 0 as zero
        do_write(0, 10'h001);
        check_outputs("R7 soft reset");
        do_read(0, got);
        chk("R7 ctrl readback", got, 16'h0380);

        // R6: hardware reset after changes
        do_write(6, 10'h0FF);
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        model_reset();
        wait_clk(4);
        check_outputs("R6 hw reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule